// File: doc/BRIEF.md
# Processor Sleep-State Entry Sequencer

This block moves the processor into one of two low-power states as a side effect of software reading one of two dedicated I/O locations. A read of the light-sleep location raises the stop-clock output at once and holds it. A read of the deep-sleep location also raises stop-clock. A fixed gap later it may raise the sleep output, and after a second gap it may raise the CPU clock-stop output. Two configuration bits decide whether each of those two deeper steps happens.

An interrupt, a system-management event or a system-control event wakes the processor. The wake drops the deeper signals in the reverse order of entry, with the same gap between steps, and releases stop-clock last. A wake event that arrives while the deep-state entry is still in progress is remembered. It takes effect as soon as the entry completes.

Both locations return zero on reads and are acknowledged one cycle after any access. A write to either location changes nothing. While a sleep state is active, further reads of the locations are acknowledged but start nothing. A busy output covers the whole time from entry until stop-clock is released.

Top module: `cpu_sleep_seq`

## Requirements
- R1: A read (`io_rd`=1) at address `L2_ADDR` (default 0x24) while idle raises `stpclk_o` in the next cycle, with `slp_o` and `cpustp_o` held low for the whole light-sleep state.
- R2: A read at address `L3_ADDR` (default 0x25) while idle raises only `stpclk_o` in the next cycle. `slp_o` may rise `GAP` cycles later, and `cpustp_o` may rise `2*GAP` cycles after the read edge.
- R3: In the deep state, `cpustp_o` is raised only if `cfg_host_stop`=1 at the read. With 0, `cpustp_o` stays low.
- R4: In the deep state, `slp_o` is raised only if `cfg_sleep_en`=1 at the read. With 0, `slp_o` stays low.
- R5: In light sleep, a pulse on any one of `wake_intr`, `wake_smi` or `wake_sci` drops `stpclk_o` in the next cycle.
- R6: In the fully entered deep state, a wake pulse drops `cpustp_o` in the next cycle. `slp_o` drops `GAP` cycles after that, and `stpclk_o` drops `GAP` cycles after `slp_o`. A wake pulse during the deep-state entry is held and applied one cycle after the entry completes.
- R7: Any read or write of either location is acknowledged (`io_ack`=1) in the next cycle, with `io_rdata`=0. A write to either location leaves all sleep outputs unchanged. Accesses to other addresses are not acknowledged.
- R8: Location reads while a sleep state is active change nothing. Wake pulses while idle change nothing.
- R9: `busy_o` is high from the cycle `stpclk_o` rises until the cycle it falls.
- R10: During and right after reset, all sleep outputs, `busy_o` and `io_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_addr | input | ADDR_W | I/O address of the access |
| io_ack | output | 1 | Access to either sleep location acknowledged |
| io_rdata | output | DATA_W | Read data, always zero |
| cfg_host_stop | input | 1 | Deep state also stops the CPU clock |
| cfg_sleep_en | input | 1 | Deep state also raises the sleep output |
| wake_intr | input | 1 | Interrupt wake event |
| wake_smi | input | 1 | System-management wake event |
| wake_sci | input | 1 | System-control wake event |
| stpclk_o | output | 1 | Stop-clock request to the processor |
| slp_o | output | 1 | Sleep request to the processor |
| cpustp_o | output | 1 | CPU clock-stop request to the clock source |
| busy_o | output | 1 | Sleep state active |

## Verification
The assertions assume that `io_rd` and `io_wr` are never high in the same cycle. They also assume that the configuration bits do not change while a sleep state is active, because the checks that tie a rising deep-sleep output to its enable bit read the live pins. The stimulus drives every access as a single-cycle strobe on a falling edge. It changes the configuration bits only while the block is idle, and it brings every sleep state back to idle before the next access.

// File: rtl/sleep_seq_pkg.sv
// Package: shared state encoding of the processor sleep-state sequencer.
// Assumes: nothing; holds types only.
package sleep_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // awake
        ST_LIGHT = 3'd1,  // stop-clock only
        ST_ENT_A = 3'd2,  // deep entry, stop-clock held, gap running
        ST_ENT_B = 3'd3,  // deep entry, sleep applied, gap running
        ST_DEEP  = 3'd4,  // deep state fully entered
        ST_EXT_B = 3'd5,  // deep exit, clock-stop dropped, gap running
        ST_EXT_A = 3'd6   // deep exit, sleep dropped, gap running
    } sleep_st_e;

endpackage

// File: rtl/sleep_io_decode.sv
// Module: decodes the two sleep locations on the I/O bus, produces the
// one-cycle acknowledge and the all-zero read data.
// Assumes: io_rd and io_wr are single-cycle strobes, never both high.
module sleep_io_decode #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter logic [ADDR_W-1:0] L2_ADDR = 'h24,
    parameter logic [ADDR_W-1:0] L3_ADDR = 'h25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              rd_light,
    output logic              rd_deep,
    output logic              io_ack,
    output logic [DATA_W-1:0] io_rdata
);

    logic hit_light, hit_deep, ack_q;

    // address match for each location
    always_comb begin
        hit_light = (io_addr == L2_ADDR);
        hit_deep  = (io_addr == L3_ADDR);
    end

    // read side effects are the only entry triggers
    assign rd_light = io_rd & hit_light;
    assign rd_deep  = io_rd & hit_deep;

    // acknowledge one cycle after any access to a sleep location
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= (io_rd | io_wr) & (hit_light | hit_deep);
    end

    assign io_ack   = ack_q;
    assign io_rdata = '0;

endmodule

// File: rtl/sleep_wake_detect.sv
// Module: merges the three wake sources and holds a wake seen during
// deep-state entry until the sequencer can act on it.
// Assumes: wake sources are already synchronous to clk.
module sleep_wake_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_intr,
    input  logic wake_smi,
    input  logic wake_sci,
    input  logic in_entry,
    output logic wake_now
);

    logic any_wake, pend_q;

    // any source wakes
    assign any_wake = wake_intr | wake_smi | wake_sci;

    // remember wakes during entry, forget them once entry is over
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (in_entry) pend_q <= pend_q | any_wake;
        else               pend_q <= 1'b0;
    end

    assign wake_now = any_wake | pend_q;

endmodule

// File: rtl/sleep_state_fsm.sv
// Module: sleep-state machine with a gap counter that spaces the deep
// entry and exit steps, and derives the processor-facing outputs.
// Assumes: GAP >= 1; configuration is latched at deep entry.
module sleep_state_fsm
    import sleep_seq_pkg::*;
#(
    parameter int GAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_light,
    input  logic rd_deep,
    input  logic wake_now,
    input  logic cfg_host_stop,
    input  logic cfg_sleep_en,
    output logic in_entry,
    output logic stpclk_o,
    output logic slp_o,
    output logic cpustp_o,
    output logic busy_o
);

    localparam int CNT_W = (GAP < 2) ? 1 : $clog2(GAP);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP - 1);

    sleep_st_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             host_q, slpen_q;
    logic             timed, gap_done;

    // states that wait out a gap
    always_comb begin
        timed    = (st_q == ST_ENT_A) || (st_q == ST_ENT_B) ||
                   (st_q == ST_EXT_B) || (st_q == ST_EXT_A);
        gap_done = timed && (cnt_q == CNT_LAST);
    end

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (rd_deep) st_d = ST_ENT_A;
                      else if (rd_light) st_d = ST_LIGHT;
            ST_LIGHT: if (wake_now) st_d = ST_IDLE;
            ST_ENT_A: if (gap_done) st_d = ST_ENT_B;
            ST_ENT_B: if (gap_done) st_d = ST_DEEP;
            ST_DEEP:  if (wake_now) st_d = ST_EXT_B;
            ST_EXT_B: if (gap_done) st_d = ST_EXT_A;
            ST_EXT_A: if (gap_done) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // gap counter, restarts on every step
    always_ff @(posedge clk) begin
        if (!rst_n || !timed || gap_done) cnt_q <= '0;
        else                             cnt_q <= cnt_q + 1'b1;
    end

    // configuration latched at deep entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_q  <= 1'b0;
            slpen_q <= 1'b0;
        end else if (st_q == ST_IDLE && rd_deep) begin
            host_q  <= cfg_host_stop;
            slpen_q <= cfg_sleep_en;
        end
    end

    // processor-facing outputs decoded from state
    always_comb begin
        stpclk_o = (st_q != ST_IDLE);
        slp_o    = slpen_q && ((st_q == ST_ENT_B) || (st_q == ST_DEEP) ||
                               (st_q == ST_EXT_B));
        cpustp_o = host_q && (st_q == ST_DEEP);
        busy_o   = (st_q != ST_IDLE);
        in_entry = (st_q == ST_ENT_A) || (st_q == ST_ENT_B);
    end

endmodule

// File: rtl/cpu_sleep_seq.sv
// Module: top of the processor sleep-state sequencer. Connects I/O
// decode, wake detection and the state machine.
// Assumes: synchronous inputs; io_rd and io_wr never high together.
module cpu_sleep_seq #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter logic [ADDR_W-1:0] L2_ADDR = 'h24,
    parameter logic [ADDR_W-1:0] L3_ADDR = 'h25,
    parameter int GAP     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              io_ack,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              cfg_host_stop,
    input  logic              cfg_sleep_en,
    input  logic              wake_intr,
    input  logic              wake_smi,
    input  logic              wake_sci,
    output logic              stpclk_o,
    output logic              slp_o,
    output logic              cpustp_o,
    output logic              busy_o
);

    logic rd_light, rd_deep, wake_now, in_entry;

    sleep_io_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .L2_ADDR(L2_ADDR), .L3_ADDR(L3_ADDR)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr),
        .io_addr(io_addr), .rd_light(rd_light), .rd_deep(rd_deep),
        .io_ack(io_ack), .io_rdata(io_rdata)
    );

    sleep_wake_detect u_wake (
        .clk(clk), .rst_n(rst_n), .wake_intr(wake_intr),
        .wake_smi(wake_smi), .wake_sci(wake_sci),
        .in_entry(in_entry), .wake_now(wake_now)
    );

    sleep_state_fsm #(.GAP(GAP)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_light(rd_light), .rd_deep(rd_deep),
        .wake_now(wake_now), .cfg_host_stop(cfg_host_stop),
        .cfg_sleep_en(cfg_sleep_en), .in_entry(in_entry),
        .stpclk_o(stpclk_o), .slp_o(slp_o), .cpustp_o(cpustp_o),
        .busy_o(busy_o)
    );

endmodule

// File: rtl/cpu_sleep_seq_checker.sv
// Module: assertion checker bound to cpu_sleep_seq; watches ports only.
// Assumes: configuration bits stay constant while a sleep state is active.
module cpu_sleep_seq_checker #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter logic [ADDR_W-1:0] L2_ADDR = 'h24,
    parameter logic [ADDR_W-1:0] L3_ADDR = 'h25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_rd,
    input logic              io_wr,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_ack,
    input logic [DATA_W-1:0] io_rdata,
    input logic              cfg_host_stop,
    input logic              cfg_sleep_en,
    input logic              stpclk_o,
    input logic              slp_o,
    input logic              cpustp_o,
    input logic              busy_o
);

    logic hit;
    assign hit = (io_addr == L2_ADDR) || (io_addr == L3_ADDR);

    AST_STP_ROSE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stpclk_o) |-> $past(io_rd && hit)); // R1
    AST_STP_RISES_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stpclk_o) |-> (!slp_o && !cpustp_o)); // R2
    AST_CPU_INSIDE_STP: assert property (@(posedge clk) disable iff (!rst_n)
        cpustp_o |-> stpclk_o); // R2
    AST_CPU_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpustp_o) |-> cfg_host_stop); // R3
    AST_SLP_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slp_o) |-> cfg_sleep_en); // R4
    AST_SLP_INSIDE_STP: assert property (@(posedge clk) disable iff (!rst_n)
        slp_o |-> stpclk_o); // R4
    AST_SLP_DROPS_AFTER_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slp_o) |-> !cpustp_o); // R6
    AST_STP_DROPS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stpclk_o) |-> (!slp_o && !cpustp_o)); // R6
    AST_ACK_FOLLOWS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && hit) |=> io_ack); // R7
    AST_ACK_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |-> (io_rdata == '0)); // R7
    AST_WRITE_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_rd && !stpclk_o) |=> !stpclk_o); // R7
    AST_BUSY_COVERS_STP: assert property (@(posedge clk) disable iff (!rst_n)
        stpclk_o |-> busy_o); // R9

endmodule

bind cpu_sleep_seq cpu_sleep_seq_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .L2_ADDR(L2_ADDR), .L3_ADDR(L3_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr),
    .io_addr(io_addr), .io_ack(io_ack), .io_rdata(io_rdata),
    .cfg_host_stop(cfg_host_stop), .cfg_sleep_en(cfg_sleep_en),
    .stpclk_o(stpclk_o), .slp_o(slp_o), .cpustp_o(cpustp_o),
    .busy_o(busy_o)
);

// File: tb/cpu_sleep_seq_bench.sv
// Bench: vector table of single accesses, then directed sequences for
// reset, deep-state steps, wake sources and ignored inputs.
module cpu_sleep_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 3;
    localparam logic [7:0] A_L2 = 8'h24;
    localparam logic [7:0] A_L3 = 8'h25;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_ack;
    logic [7:0] io_rdata;
    logic       cfg_host_stop = 1'b0, cfg_sleep_en = 1'b0;
    logic       wake_intr = 1'b0, wake_smi = 1'b0, wake_sci = 1'b0;
    logic       stpclk_o, slp_o, cpustp_o, busy_o;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_sleep_seq #(.GAP(GAP)) u_cpu_sleep_seq (
        .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr),
        .io_addr(io_addr), .io_ack(io_ack), .io_rdata(io_rdata),
        .cfg_host_stop(cfg_host_stop), .cfg_sleep_en(cfg_sleep_en),
        .wake_intr(wake_intr), .wake_smi(wake_smi), .wake_sci(wake_sci),
        .stpclk_o(stpclk_o), .slp_o(slp_o), .cpustp_o(cpustp_o),
        .busy_o(busy_o)
    );

    // vector: addr, write, expected stop-clock, expected ack
    typedef struct packed {
        logic [7:0] addr;
        logic       wr;
        logic       exp_stp;
        logic       exp_ack;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'h24, 1'b0, 1'b1, 1'b1},
        '{8'h25, 1'b0, 1'b1, 1'b1},
        '{8'h24, 1'b1, 1'b0, 1'b1},
        '{8'h25, 1'b1, 1'b0, 1'b1},
        '{8'h26, 1'b0, 1'b0, 1'b0},
        '{8'h23, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [7:0] a, input logic wr);
        io_addr = a; io_rd = !wr; io_wr = wr;
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0;
    endtask

    task automatic pulse(input int src);
        case (src)
            0: wake_intr = 1'b1;
            1: wake_smi  = 1'b1;
            default: wake_sci = 1'b1;
        endcase
        @(negedge clk);
        wake_intr = 1'b0; wake_smi = 1'b0; wake_sci = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic deep_run(input logic host, input logic slpen);
        cfg_host_stop = host; cfg_sleep_en = slpen;
        access(A_L3, 1'b0);
        chk("R2 stp on entry", stpclk_o, 1);
        chk("R2 slp low at entry", slp_o, 0);
        chk("R9 busy on entry", busy_o, 1);
        idle(GAP-1);
        chk("R2 slp still low before gap", slp_o, 0);
        idle(1);
        chk("R4 slp after gap", slp_o, slpen);
        chk("R2 cpu low before second gap", cpustp_o, 0);
        idle(GAP);
        chk("R3 cpu after two gaps", cpustp_o, host);
        chk("R4 slp held in deep", slp_o, slpen);
        pulse(0);
        chk("R6 cpu drops first", cpustp_o, 0);
        chk("R6 slp held one gap", slp_o, slpen);
        idle(GAP);
        chk("R6 slp dropped", slp_o, 0);
        chk("R6 stp held", stpclk_o, 1);
        idle(GAP);
        chk("R6 stp dropped", stpclk_o, 0);
        chk("R9 busy dropped", busy_o, 0);
        cfg_host_stop = 1'b0; cfg_sleep_en = 1'b0;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        chk("R10 stp in reset", stpclk_o, 0);
        chk("R10 ack in reset", io_ack, 0);
        rst_n = 1'b1;
        idle(1);
        chk("R10 stp after reset", stpclk_o, 0);
        chk("R10 slp after reset", slp_o, 0);
        chk("R10 cpu after reset", cpustp_o, 0);
        chk("R10 busy after reset", busy_o, 0);

        // table walk: one access, check effect, then wake back to idle
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].addr, VECS[i].wr);
            chk("R1 R7 table stp", stpclk_o, VECS[i].exp_stp);
            chk("R7 table ack", io_ack, VECS[i].exp_ack);
            chk("R7 table rdata", io_rdata, 8'h00);
            pulse(1);
            idle(5*GAP);
            chk("R5 table back idle", busy_o, 0);
        end

        // R1: light sleep keeps deeper outputs low, then R5 per source
        for (int s = 0; s < 3; s++) begin
            cfg_host_stop = 1'b1; cfg_sleep_en = 1'b1;
            access(A_L2, 1'b0);
            idle(3*GAP);
            chk("R1 light stp held", stpclk_o, 1);
            chk("R1 light slp low", slp_o, 0);
            chk("R1 light cpu low", cpustp_o, 0);
            pulse(s);
            chk("R5 wake releases stp", stpclk_o, 0);
            chk("R9 busy released", busy_o, 0);
        end
        cfg_host_stop = 1'b0; cfg_sleep_en = 1'b0;

        // deep state under all four configurations
        deep_run(1'b0, 1'b0);
        deep_run(1'b1, 1'b0);
        deep_run(1'b0, 1'b1);
        deep_run(1'b1, 1'b1);

        // R8: deep read while in light sleep is ignored
        cfg_host_stop = 1'b1; cfg_sleep_en = 1'b1;
        access(A_L2, 1'b0);
        access(A_L3, 1'b0);
        chk("R7 ack while busy", io_ack, 1);
        idle(3*GAP);
        chk("R8 no slp from busy read", slp_o, 0);
        chk("R8 no cpu from busy read", cpustp_o, 0);
        pulse(2);
        chk("R5 sci wake", stpclk_o, 0);

        // R8: wake while idle does nothing; a later read still enters
        pulse(0);
        pulse(1);
        pulse(2);
        chk("R8 idle wake no effect", busy_o, 0);
        access(A_L2, 1'b0);
        chk("R8 entry after idle wake", stpclk_o, 1);
        pulse(0);

        // R6: wake during deep entry is held until entry completes
        access(A_L3, 1'b0);
        pulse(1);
        idle(2*GAP-1);
        chk("R6 entry completes despite early wake", cpustp_o, 1);
        idle(1);
        chk("R6 held wake drops cpu", cpustp_o, 0);
        chk("R6 held wake slp still up", slp_o, 1);
        idle(GAP);
        chk("R6 held wake slp dropped", slp_o, 0);
        idle(GAP);
        chk("R6 held wake stp dropped", stpclk_o, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule